// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM with a 64-word by 16-bit array. The host drives a chip select, a serial clock and a data input line. The block answers on a data output that has a separate output enable, so the output can be left undriven. All three host lines are sampled on the block's own system clock. A rising serial clock is found by comparing each sample with the one before it, so the system clock must run several times faster than the serial clock.

Each frame opens with a start bit of 1. Two opcode bits and six address bits follow, most significant first. Depending on the opcode, a 16-bit data word may follow as well.
- Reads stream data out, MSB first.
- Writes, single-word erase, erase-all and write-all load a job that starts when chip select falls. The job then times itself on the system clock, with no serial clock needed.
- While a job runs, the host can raise chip select again after a minimum low time and poll the output: 0 means busy, 1 means ready.

The host pins carry only serial bits, so there is no valid/ready handshake and no back-pressure. A host that ignores the busy status simply has its frames dropped while a job runs.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, do_oe is 0, every word of the array reads 0xFFFF, and the write-enable latch is clear.
- R2: A read frame is 1, opcode 10, then A5..A0. do_oe stays 0 until the rising serial clock that carries A0. After that edge the output drives a single 0, and each further rising edge presents the next data bit, MSB first.
- R3: If serial clocks continue after the 16th data bit, a read moves on to the next address. Address 63 is followed by address 0.
- R4: A write frame is 1, opcode 01, the address, then 16 data bits MSB first. The word is programmed only by a job that starts at the falling edge of chip select after the last data bit.
- R5: If a rising serial clock arrives while chip select is still high after the last bit of a write-type frame, that frame is dropped. The array stays unchanged and no job starts.
- R6: A job lasts UNIT_CYC system cycles for a write or an erase, 2*UNIT_CYC for erase-all and 4*UNIT_CYC for write-all, counted from the first clock that sees chip select low. While a job runs, raising chip select after at least CSL_CYC low cycles makes do_oe 1 and do_o 0 (busy). do_o becomes 1 once the job is done. After a shorter low time, do_oe stays 0.
- R7: Opcode 11 followed by an address sets that word to 0xFFFF. Opcode 00 with A5..A4 = 10 sets every word to 0xFFFF.
- R8: Opcode 00 with A5..A4 = 01, followed by a 16-bit word, writes that word to every location. No separate erase is needed first.
- R9: Opcode 00 with A5..A4 = 11 sets the write-enable latch, and with A5..A4 = 00 clears it. While the latch is clear, write, erase, erase-all and write-all start no job and leave the array unchanged.
- R10: Any frame clocked in while a job runs is ignored.
- R11: When chip select is low and no read is in progress, do_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all host pins and times jobs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or ready/busy status |
| do_oe | output | 1 | Output enable for do_o; 0 means high impedance |

## Verification
Reads are tried at fixed and random addresses, and also as two- and three-word bursts that cross from the top address to address 0. These tell a correct data path apart from an off-by-one in bit order, in the dummy bit, or in address increment and wrap. The timing of each job type is measured exactly from the fall of chip select to the first ready sample, so a wrong length multiplier shows up at once. Frames sent with writes disabled, a frame with one serial clock too many, a frame sent during a job and a too-short deselect each test that one rule for ignoring input; the array is read back afterwards to confirm nothing changed.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    L_IDLE, L_OPC, L_ADR, L_DAT, L_ARM, L_RD, L_DONE
  } link_st_t;

  typedef enum logic [1:0] {
    J_WRITE, J_ERASE, J_ERAL, J_WRAL
  } job_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK  = 2'b00;
  localparam logic [1:0] EXT_FILL  = 2'b01;
  localparam logic [1:0] EXT_WIPE  = 2'b10;
  localparam logic [1:0] EXT_OPEN  = 2'b11;
endpackage

// File: rtl/mw_link.sv
module mw_link
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              di,
  input  logic              busy,
  output logic              job_go,
  output job_t              job_kind,
  output logic [ADDR_W-1:0] job_addr,
  output logic [DATA_W-1:0] job_data,
  output logic              wen_set,
  output logic              wen_clr,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_do,
  output logic              rd_oe,
  output logic              idle
);
  localparam int MAXN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW   = $clog2(MAXN) + 1;

  link_st_t          st;
  logic              sclk_q, cs_q;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-1:0] dat, rd_sh;
  logic [CW-1:0]     cnt;
  job_t              kind;
  logic              rise, cs_fall;
  logic [ADDR_W-1:0] a_next;

  assign rise    = sclk & ~sclk_q;
  assign cs_fall = cs_q & ~cs;
  assign a_next  = {adr[ADDR_W-2:0], di};
  assign rd_addr = (st == L_RD) ? adr + ADDR_W'(1) : a_next;
  assign job_go  = cs_fall && (st == L_ARM);
  assign job_kind = kind;
  assign job_addr = adr;
  assign job_data = dat;
  assign idle     = (st == L_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; sclk_q <= 1'b0; cs_q <= 1'b0;
      opc <= '0; adr <= '0; dat <= '0; rd_sh <= '0; cnt <= '0;
      kind <= J_WRITE; rd_do <= 1'b0; rd_oe <= 1'b0;
      wen_set <= 1'b0; wen_clr <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs;
      wen_set <= 1'b0;
      wen_clr <= 1'b0;
      if (!cs) begin
        st    <= L_IDLE;
        rd_oe <= 1'b0;
      end else if (rise && !busy) begin
        case (st)
          L_IDLE: if (di) begin st <= L_OPC; cnt <= '0; end
          L_OPC: begin
            opc <= {opc[0], di};
            cnt <= cnt + CW'(1);
            if (cnt == CW'(1)) begin st <= L_ADR; cnt <= '0; end
          end
          L_ADR: begin
            adr <= a_next;
            cnt <= cnt + CW'(1);
            if (cnt == CW'(ADDR_W - 1)) begin
              cnt <= '0;
              case (opc)
                OPC_READ: begin
                  st <= L_RD; rd_sh <= rd_data; rd_do <= 1'b0; rd_oe <= 1'b1;
                end
                OPC_WRITE: begin st <= L_DAT; kind <= J_WRITE; end
                OPC_ERASE: begin st <= L_ARM; kind <= J_ERASE; end
                default: begin
                  case (a_next[ADDR_W-1 -: 2])
                    EXT_OPEN: begin st <= L_DONE; wen_set <= 1'b1; end
                    EXT_LOCK: begin st <= L_DONE; wen_clr <= 1'b1; end
                    EXT_WIPE: begin st <= L_ARM; kind <= J_ERAL; end
                    default:  begin st <= L_DAT; kind <= J_WRAL; end
                  endcase
                end
              endcase
            end
          end
          L_DAT: begin
            dat <= {dat[DATA_W-2:0], di};
            cnt <= cnt + CW'(1);
            if (cnt == CW'(DATA_W - 1)) st <= L_ARM;
          end
          L_ARM: st <= L_DONE;
          L_RD: begin
            rd_do <= rd_sh[DATA_W-1];
            rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            cnt   <= cnt + CW'(1);
            if (cnt == CW'(DATA_W - 1)) begin
              cnt   <= '0;
              adr   <= adr + ADDR_W'(1);
              rd_sh <= rd_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  rd_oe_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> ($past(st) == L_ADR) && !rd_do);

  // R11
  rd_oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !rd_oe);
endmodule

// File: rtl/mw_prog.sv
module mw_prog
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int UNIT_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_go,
  input  job_t              job_kind,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [DATA_W-1:0] job_data,
  input  logic              wen_set,
  input  logic              wen_clr,
  output logic              busy,
  output logic              commit,
  output job_t              c_kind,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);
  localparam int TW = $clog2(4 * UNIT_CYC + 1);

  logic          wen;
  logic [TW-1:0] tmr;

  function automatic logic [TW-1:0] cyc_len(job_t k);
    case (k)
      J_ERAL:  return TW'(2 * UNIT_CYC - 1);
      J_WRAL:  return TW'(4 * UNIT_CYC - 1);
      default: return TW'(UNIT_CYC - 1);
    endcase
  endfunction

  assign commit = busy && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0; busy <= 1'b0; tmr <= '0;
      c_kind <= J_WRITE; c_addr <= '0; c_data <= '0;
    end else begin
      if (wen_set) wen <= 1'b1;
      else if (wen_clr) wen <= 1'b0;
      if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else tmr <= tmr - TW'(1);
      end else if (job_go && wen) begin
        busy   <= 1'b1;
        tmr    <= cyc_len(job_kind);
        c_kind <= job_kind;
        c_addr <= job_addr;
        c_data <= job_data;
      end
    end
  end

  // R9
  start_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_go && !wen && !busy |=> !busy);

  // R10
  timer_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (tmr != '0) |=> busy && (tmr == $past(tmr) - TW'(1)) && $stable(c_addr) && $stable(c_data));
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  job_t              c_kind,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rd_bus [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = (c_addr == ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else if (commit) begin
        case (c_kind)
          J_WRITE: if (hit) q <= c_data;
          J_ERASE: if (hit) q <= '1;
          J_ERAL:  q <= '1;
          default: q <= c_data;
        endcase
      end
    end
    assign rd_bus[w] = q;
  end

  assign rd_data = rd_bus[rd_addr];

  // R7
  eral_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (c_kind == J_ERAL) |=> (rd_bus[0] == '1) && (rd_bus[DEPTH-1] == '1));

  // R8
  wral_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (c_kind == J_WRAL) |=> (rd_bus[0] == $past(c_data)) && (rd_bus[DEPTH-1] == $past(c_data)));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int UNIT_CYC = 40,
  parameter int CSL_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int LW = $clog2(CSL_CYC + 1);

  logic              job_go, wen_set, wen_clr, busy, commit;
  logic              rd_do, rd_oe, lnk_idle;
  job_t              job_kind, c_kind;
  logic [ADDR_W-1:0] job_addr, c_addr, rd_addr;
  logic [DATA_W-1:0] job_data, c_data, rd_data;
  logic              cs_q, stat_mode, low_ok, st_oe;
  logic [LW-1:0]     lowcnt;

  mw_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di), .busy(busy),
    .job_go(job_go), .job_kind(job_kind), .job_addr(job_addr), .job_data(job_data),
    .wen_set(wen_set), .wen_clr(wen_clr), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_do(rd_do), .rd_oe(rd_oe), .idle(lnk_idle)
  );

  mw_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIT_CYC(UNIT_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n), .job_go(job_go), .job_kind(job_kind),
    .job_addr(job_addr), .job_data(job_data), .wen_set(wen_set), .wen_clr(wen_clr),
    .busy(busy), .commit(commit), .c_kind(c_kind), .c_addr(c_addr), .c_data(c_data)
  );

  mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_kind(c_kind), .c_addr(c_addr),
    .c_data(c_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign low_ok = (lowcnt >= LW'(CSL_CYC));
  assign st_oe  = cs && stat_mode && low_ok && lnk_idle;
  assign do_oe  = rd_oe | st_oe;
  assign do_o   = rd_oe ? rd_do : (st_oe ? ~busy : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0; lowcnt <= '0; stat_mode <= 1'b0;
    end else begin
      cs_q <= cs;
      if (cs_q && !cs) lowcnt <= '0;
      else if (!cs && !low_ok) lowcnt <= lowcnt + LW'(1);
      if (busy) stat_mode <= 1'b1;
      else if ((cs_q && !cs) || (cs && !lnk_idle)) stat_mode <= 1'b0;
    end
  end

  // R10
  idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lnk_idle);

  // R11
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs && $past(!cs) && !busy |-> !do_oe);
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int AW = 6, DW = 16, UNIT = 256, CSL = 4, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int   n_chk = 0, n_fail = 0;
  logic [DW-1:0] model [DEPTH];
  bit   wen_m = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .UNIT_CYC(UNIT), .CSL_CYC(CSL)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  function automatic int job_len(int kind);  // 0 write/erase, 1 eral, 2 wral
    return (kind == 2) ? 4 * UNIT : (kind == 1) ? 2 * UNIT : UNIT;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_clk(logic b);
    @(negedge clk); di = b; sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(logic [1:0] opc, logic [AW-1:0] a, bit has_d, logic [DW-1:0] d, bit extra);
    @(negedge clk); cs = 1'b1;
    bit_clk(1'b1);
    for (int i = 1; i >= 0; i--) bit_clk(opc[i]);
    for (int i = AW - 1; i >= 0; i--) bit_clk(a[i]);
    if (has_d) for (int i = DW - 1; i >= 0; i--) bit_clk(d[i]);
    if (extra) bit_clk(1'b0);
  endtask

  task automatic cs_off(int n);
    @(negedge clk); cs = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // lowers cs, raises it after a long low time, and times the job
  task automatic timed_end(int exp_len, string tag);
    int t = 0;
    @(negedge clk); cs = 1'b0;
    repeat (CSL + 2) begin @(negedge clk); t++; end
    cs = 1'b1; #1;
    chk(do_oe === 1'b1 && do_o === 1'b0, {tag, " busy status"}, {do_oe, do_o}, 2'b10);
    while (!(do_oe === 1'b1 && do_o === 1'b1) && t < 8 * UNIT) begin
      @(negedge clk); t++;
    end
    chk(t == exp_len + 1, {tag, " job length"}, t, exp_len + 1);
    cs_off(2);
  endtask

  // lowers cs and confirms that no job started
  task automatic no_job(string tag);
    @(negedge clk); cs = 1'b0;
    repeat (CSL + 2) @(negedge clk);
    cs = 1'b1; #1;
    chk(do_oe === 1'b0, {tag, " no job started"}, do_oe, 0);
    cs_off(2);
  endtask

  task automatic rd_check(logic [AW-1:0] a, int n, string tag);
    logic [DW-1:0] got;
    @(negedge clk); cs = 1'b1;
    bit_clk(1'b1); bit_clk(1'b1); bit_clk(1'b0);
    for (int i = AW - 1; i >= 1; i--) bit_clk(a[i]);
    chk(do_oe === 1'b0, {tag, " R2 hi-z before A0"}, do_oe, 0);
    bit_clk(a[0]);
    chk(do_oe === 1'b1 && do_o === 1'b0, {tag, " R2 dummy zero"}, {do_oe, do_o}, 2'b10);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < DW; b++) begin
        bit_clk(1'b0);
        got = {got[DW-2:0], do_o};
      end
      chk(got === model[AW'(a + AW'(w))], tag, got, model[AW'(a + AW'(w))]);
    end
    cs_off(2);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    frame(2'b01, a, 1'b1, d, 1'b0);
    if (wen_m) begin model[a] = d; timed_end(job_len(0), tag); end
    else no_job(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    chk(do_oe === 1'b0, "R1 do_oe at reset", do_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(do_oe === 1'b0, "R11 idle hi-z", do_oe, 0);

    // R1 / R9: latch clear after reset, write ignored
    do_write(6'd5, 16'h1234, "R1 R9 write while locked");
    rd_check(6'd5, 1, "R1 reset contents");

    // R9: open latch, R4 write, R6 timing
    frame(2'b00, 6'b110000, 1'b0, '0, 1'b0); cs_off(2); wen_m = 1'b1;
    do_write(6'd5, 16'hA5C3, "R4 R6 write");
    rd_check(6'd5, 1, "R4 read back");

    // R6 short deselect, R10 frame during job ignored
    frame(2'b01, 6'd9, 1'b1, 16'h0F1E, 1'b0); model[9] = 16'h0F1E;
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1; #1;
    chk(do_oe === 1'b0, "R6 short low gives no status", do_oe, 0);
    cs_off(CSL + 3);
    cs = 1'b1; #1;
    chk(do_oe === 1'b1 && do_o === 1'b0, "R6 busy after long low", {do_oe, do_o}, 2'b10);
    cs_off(2);
    @(negedge clk); cs = 1'b1;
    bit_clk(1'b1); bit_clk(1'b0); bit_clk(1'b1);
    for (int i = 0; i < AW; i++) bit_clk(1'b0);
    cs_off(2);
    repeat (UNIT) @(negedge clk);
    rd_check(6'd9, 1, "R10 write kept");
    rd_check(6'd0, 1, "R10 ignored frame left word 0");

    // R5 abandoned write
    frame(2'b01, 6'd12, 1'b1, 16'h7777, 1'b1);
    no_job("R5 abandoned");
    rd_check(6'd12, 1, "R5 word unchanged");

    // R7 single erase
    frame(2'b11, 6'd5, 1'b0, '0, 1'b0); model[5] = '1;
    timed_end(job_len(0), "R7 erase");
    rd_check(6'd5, 1, "R7 erased word");

    // R8 write-all, R3 wrap
    frame(2'b00, 6'b010000, 1'b1, 16'h3C5A, 1'b0);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h3C5A;
    timed_end(job_len(2), "R8 write-all");
    do_write(6'd63, 16'hBEEF, "R4 write top");
    do_write(6'd0, 16'h0101, "R4 write bottom");
    rd_check(6'd62, 3, "R3 R8 burst wraps");

    // R7 erase-all
    frame(2'b00, 6'b100000, 1'b0, '0, 1'b0);
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    timed_end(job_len(1), "R7 erase-all");
    rd_check(6'd63, 2, "R7 erase-all contents");

    // R9 lock again
    frame(2'b00, 6'b000000, 1'b0, '0, 1'b0); cs_off(2); wen_m = 1'b0;
    do_write(6'd20, 16'h5555, "R9 write while locked");
    frame(2'b00, 6'b010000, 1'b1, 16'h0000, 1'b0);
    no_job("R9 write-all while locked");
    rd_check(6'd20, 1, "R9 locked word");

    // random writes and bursts
    frame(2'b00, 6'b111111, 1'b0, '0, 1'b0); cs_off(2); wen_m = 1'b1;
    for (int k = 0; k < 14; k++) begin
      ra = AW'($urandom);
      rd = DW'($urandom);
      do_write(ra, rd, "R4 random write");
      rd_check(AW'($urandom), 2, "R2 R3 random burst");
    end

    cs_off(2);
    chk(do_oe === 1'b0, "R11 final hi-z", do_oe, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule